// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block is a small data cache that sits between a requester issuing word loads and stores and a plain word-addressed backing memory. A word address splits into three fields. The low bits give the word offset inside a block. The next bits give the set number. The remaining high bits form the tag. Each set has two ways, and the tags of both ways are compared in the same cycle. A read hit returns data one cycle after the request is accepted, and the backing memory sees no traffic.

On a miss the requester is stalled while the block is fetched. If an empty way exists it takes the new block. Otherwise the least recently used way is chosen, using one bit kept per set. A victim that is both valid and modified is first written back to memory one word at a time, in ascending order. The missing block is then read in the same way. Finally the original request is served against the freshly filled way. Stores that hit change only the cached word, under byte enables, and mark the block modified.

Top module: `cache2w`

## Requirements
- R1: After reset, every way is empty and no block is modified or recently used. `reqReady` is high, and `rspValid` and `memValid` are low. The first access to any address misses.
- R2: A word address splits into three fields. The low log2(BLK_WORDS) bits are the offset, the next log2(SETS) bits are the set, and the rest is the tag. Every memory transfer uses the address {tag, set, word count}.
- R3: A read hit raises `rspValid` for one cycle, in the cycle after the accepting edge. It carries the stored word and causes no memory transfer.
- R4: Once a missing request is accepted, `reqReady` stays low until its response. `memValid` is never high while `reqReady` is high.
- R5: On a miss, an empty way is filled before any valid block is replaced, and way 0 is taken before way 1.
- R6: When both ways are valid, the victim is the way not used most recently. Every read or write, whether a hit or served after a refill, marks the other way of that set as next victim.
- R7: A write hit changes only the bytes whose `reqStrb` bit is 1 (bit b covers data bits 8b+7..8b). It marks the block modified and causes no memory transfer.
- R8: A modified victim is written back word by word, with `memWrite`=1 and offsets ascending, before any read of the new block. A clean victim is never written back.
- R9: A refill reads the block's words with offsets ascending, one per handshake. `rspValid` rises two cycles after the last read handshake, carrying the requested word after any write has been merged.
- R10: While `memValid` is high and `memReady` is low, `memValid`, `memWrite` and `memAddr` hold their values into the next cycle.
- R11: With two sets and one-word blocks, starting empty, the read sequence 0,2,0,1,4,0,2,3,5,4 hits on exactly the 3rd and 6th accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Cache can accept a request |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Store data |
| reqStrb | input | DATA_W/8 | Byte enables for a store |
| rspValid | output | 1 | One-cycle response pulse |
| rspRdata | output | DATA_W | Word after the access |
| memValid | output | 1 | Memory transfer request |
| memReady | input | 1 | Memory accepts the transfer this cycle |
| memWrite | output | 1 | 1 = write-back word, 0 = refill read |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Write-back data |
| memRdata | input | DATA_W | Refill data, valid with memReady |

## Verification
The bench builds the cache with SETS=2, BLK_WORDS=1, ADDR_W=6 and DATA_W=32. With four one-word blocks, a short address sequence fills both ways of a set, and conflict evictions appear within a few accesses. This makes the empty-way preference, the single-bit recency order and the fixed ten-access hit pattern directly observable. The 64-word address space sends the random traffic through many dirty evictions and partial-byte stores, while `memReady` stalls at random.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_DONE
  } cacheState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture the incoming request
    logic useLatch;   // look up with the captured request
    logic doAccess;   // perform the hit access and answer
    logic cntClr;     // clear the word counter
    logic cntInc;     // advance the word counter
    logic fillWord;   // store memRdata into the victim way
    logic fillDone;   // mark the victim way valid and clean
  } cacheCtl_t;

endpackage

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      hit,
  input  logic      victimDirty,
  input  logic      lastWord,
  input  logic      memReady,
  output logic      reqReady,
  output logic      memValid,
  output logic      memWrite,
  output cacheCtl_t ctl
);

  cacheState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    reqReady  = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          if (hit) begin
            ctl.doAccess = 1'b1;
          end else begin
            ctl.cntClr = 1'b1;
            nextState  = victimDirty ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        ctl.useLatch = 1'b1;
        memValid     = 1'b1;
        memWrite     = 1'b1;
        if (memReady) begin
          if (lastWord) begin
            ctl.cntClr = 1'b1;
            nextState  = ST_FILL;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
      end
      ST_FILL: begin
        ctl.useLatch = 1'b1;
        memValid     = 1'b1;
        if (memReady) begin
          ctl.fillWord = 1'b1;
          if (lastWord) begin
            ctl.fillDone = 1'b1;
            ctl.cntClr   = 1'b1;
            nextState    = ST_DONE;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
      end
      ST_DONE: begin
        ctl.useLatch = 1'b1;
        ctl.doAccess = 1'b1;
        nextState    = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/cache2w_dpath.sv
module cache2w_dpath
  import cache2w_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SETS      = 8,
  parameter int BLK_WORDS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  cacheCtl_t           ctl,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqStrb,
  input  logic                memWrite,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                hit,
  output logic                victimDirty,
  output logic                lastWord,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata
);

  localparam int STRB_W   = DATA_W / 8;
  localparam int OFF_BITS = $clog2(BLK_WORDS);
  localparam int IDX_BITS = $clog2(SETS);
  localparam int TAG_SH   = OFF_BITS + IDX_BITS;
  localparam int TAG_W    = ADDR_W - TAG_SH;
  localparam int CNT_W    = (OFF_BITS > 0) ? OFF_BITS : 1;
  localparam int SLOTS    = SETS * 2;

  logic              validArr [SLOTS];
  logic              dirtyArr [SLOTS];
  logic [TAG_W-1:0]  tagArr   [SLOTS];
  logic              lruArr   [SETS];
  logic [DATA_W-1:0] dataArr  [SLOTS*BLK_WORDS];

  logic [ADDR_W-1:0] latAddr;
  logic              latWrite;
  logic [DATA_W-1:0] latWdata;
  logic [STRB_W-1:0] latStrb;
  logic [CNT_W-1:0]  wordCnt;

  logic [ADDR_W-1:0] curAddr;
  logic              curWrite;
  logic [DATA_W-1:0] curWdata;
  logic [STRB_W-1:0] curStrb;
  logic [TAG_W-1:0]  curTag;
  int                setI, offI, cntI, hitSlot, vicSlot;
  logic [1:0]        wayHit;
  logic              hitWay, victimWay;
  logic [DATA_W-1:0] oldWord, mergedWord;

  assign curAddr  = ctl.useLatch ? latAddr  : reqAddr;
  assign curWrite = ctl.useLatch ? latWrite : reqWrite;
  assign curWdata = ctl.useLatch ? latWdata : reqWdata;
  assign curStrb  = ctl.useLatch ? latStrb  : reqStrb;

  always_comb begin
    setI   = (int'(curAddr) >> OFF_BITS) % SETS;
    offI   = int'(curAddr) % BLK_WORDS;
    curTag = TAG_W'(int'(curAddr) >> TAG_SH);
    cntI   = int'(wordCnt);
  end

  // parallel tag compare, one comparator per way
  for (genvar w = 0; w < 2; w++) begin : g_way
    assign wayHit[w] = validArr[setI*2+w] && (tagArr[setI*2+w] == curTag);
  end

  assign hit    = |wayHit;
  assign hitWay = wayHit[1];

  always_comb begin
    if (!validArr[setI*2])        victimWay = 1'b0;
    else if (!validArr[setI*2+1]) victimWay = 1'b1;
    else                          victimWay = lruArr[setI];
    hitSlot = setI * 2 + int'(hitWay);
    vicSlot = setI * 2 + int'(victimWay);
  end

  assign victimDirty = validArr[vicSlot] && dirtyArr[vicSlot];
  assign lastWord    = (cntI == BLK_WORDS - 1);
  assign oldWord     = dataArr[hitSlot*BLK_WORDS+offI];
  assign memWdata    = dataArr[vicSlot*BLK_WORDS+cntI];
  assign memAddr     = ADDR_W'(((memWrite ? int'(tagArr[vicSlot]) : int'(curTag)) << TAG_SH)
                               | (setI << OFF_BITS) | cntI);

  always_comb begin
    mergedWord = oldWord;
    for (int b = 0; b < STRB_W; b++) begin
      if (curWrite && curStrb[b]) mergedWord[8*b+:8] = curWdata[8*b+:8];
    end
  end

  // state bits that reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) begin
        validArr[i] <= 1'b0;
        dirtyArr[i] <= 1'b0;
      end
      for (int s = 0; s < SETS; s++) lruArr[s] <= 1'b0;
      rspValid <= 1'b0;
      wordCnt  <= '0;
    end else begin
      rspValid <= ctl.doAccess;
      if (ctl.cntClr)      wordCnt <= '0;
      else if (ctl.cntInc) wordCnt <= wordCnt + CNT_W'(1);
      if (ctl.doAccess) begin
        lruArr[setI] <= ~hitWay;
        if (curWrite) dirtyArr[hitSlot] <= 1'b1;
      end
      if (ctl.fillDone) begin
        validArr[vicSlot] <= 1'b1;
        dirtyArr[vicSlot] <= 1'b0;
      end
    end
  end

  // storage without reset
  always_ff @(posedge clk) begin
    if (ctl.latchReq) begin
      latAddr  <= reqAddr;
      latWrite <= reqWrite;
      latWdata <= reqWdata;
      latStrb  <= reqStrb;
    end
    if (ctl.fillWord) dataArr[vicSlot*BLK_WORDS+cntI] <= memRdata;
    if (ctl.fillDone) tagArr[vicSlot] <= curTag;
    if (ctl.doAccess) begin
      rspRdata <= mergedWord;
      if (curWrite) dataArr[hitSlot*BLK_WORDS+offI] <= mergedWord;
    end
  end

endmodule

// File: rtl/cache2w.sv
module cache2w
  import cache2w_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SETS      = 8,
  parameter int BLK_WORDS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqStrb,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                memValid,
  input  logic                memReady,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata
);

  cacheCtl_t ctl;
  logic      hit, victimDirty, lastWord;

  cache2w_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit),
    .victimDirty(victimDirty), .lastWord(lastWord), .memReady(memReady),
    .reqReady(reqReady), .memValid(memValid), .memWrite(memWrite), .ctl(ctl)
  );

  cache2w_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .BLK_WORDS(BLK_WORDS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqStrb(reqStrb), .memWrite(memWrite),
    .memRdata(memRdata), .hit(hit), .victimDirty(victimDirty),
    .lastWord(lastWord), .rspValid(rspValid), .rspRdata(rspRdata),
    .memAddr(memAddr), .memWdata(memWdata)
  );

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memValid,
  input logic              memReady,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (reqReady && !memValid && !rspValid));

  p_stall_no_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !reqReady);

  p_rsp_origin_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(reqValid && reqReady) || $past(memValid && memReady && !memWrite, 2)));

  p_rsp_then_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady);

  p_wb_then_more_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite && memReady) |=> memValid);

  p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)));

endmodule

bind cache2w cache2w_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .memValid(memValid), .memReady(memReady),
  .memWrite(memWrite), .memAddr(memAddr)
);

// File: tb/cache2w_tb.sv
module cache2w_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 32;
  localparam int SETS       = 2;
  localparam int BW         = 1;
  localparam int MEM_N      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid, reqReady, reqWrite;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [3:0]        reqStrb;
  logic              rspValid;
  logic [DATA_W-1:0] rspRdata;
  logic              memValid, memReady, memWrite;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata, memRdata;

  cache2w #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .BLK_WORDS(BW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqStrb(reqStrb),
    .rspValid(rspValid), .rspRdata(rspRdata), .memValid(memValid),
    .memReady(memReady), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lastHs = 0;
  int wbCount = 0;
  int evQ[$];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // backing memory, answers in the handshake cycle
  logic [DATA_W-1:0] bmem [MEM_N];
  assign memRdata = bmem[memAddr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN && memValid && memReady) begin
      evQ.push_back(memWrite ? 1000 + int'(memAddr) : int'(memAddr));
      lastHs <= cyc;
      if (memWrite) bmem[memAddr] <= memWdata;
    end
  end

  // per-cycle port checks and memory stall pattern
  logic              pendStall = 1'b0;
  logic [ADDR_W-1:0] pendAddr  = '0;
  logic              pendWr    = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memValid) check("R4", "reqReady during memory traffic", {31'd0, reqReady}, 32'd0);
      if (pendStall) begin
        check("R10", "memValid held", {31'd0, memValid}, 32'd1);
        check("R10", "memAddr held", {26'd0, memAddr}, {26'd0, pendAddr});
        check("R10", "memWrite held", {31'd0, memWrite}, {31'd0, pendWr});
      end
    end
    memReady  = ($urandom % 4) != 0;
    pendStall = rstN && memValid && !memReady;
    pendAddr  = memAddr;
    pendWr    = memWrite;
  end

  // behavioural reference of the policy
  bit                mv  [SETS][2];
  bit                md  [SETS][2];
  int                mt  [SETS][2];
  bit                ml  [SETS];
  logic [DATA_W-1:0] mdat[SETS][2][BW];
  logic [DATA_W-1:0] refMem[MEM_N];

  task automatic modelAccess(bit wr, int addr, logic [31:0] wd, logic [3:0] st,
                             output bit isHit, output logic [31:0] rd, ref int exQ[$]);
    int set = (addr / BW) % SETS;
    int tag = addr / (BW * SETS);
    int off = addr % BW;
    int hw  = -1;
    logic [31:0] word;
    for (int w = 0; w < 2; w++) if (mv[set][w] && mt[set][w] == tag) hw = w;
    isHit = (hw >= 0);
    if (hw < 0) begin
      int vic = !mv[set][0] ? 0 : (!mv[set][1] ? 1 : int'(ml[set]));
      if (mv[set][vic] && md[set][vic]) begin
        for (int k = 0; k < BW; k++) begin
          int a = (mt[set][vic] * SETS + set) * BW + k;
          refMem[a] = mdat[set][vic][k];
          exQ.push_back(1000 + a);
        end
      end
      for (int k = 0; k < BW; k++) begin
        int a = (tag * SETS + set) * BW + k;
        mdat[set][vic][k] = refMem[a];
        exQ.push_back(a);
      end
      mv[set][vic] = 1'b1;
      md[set][vic] = 1'b0;
      mt[set][vic] = tag;
      hw = vic;
    end
    word = mdat[set][hw][off];
    if (wr) begin
      for (int b = 0; b < 4; b++) if (st[b]) word[8*b+:8] = wd[8*b+:8];
      mdat[set][hw][off] = word;
      md[set][hw] = 1'b1;
    end
    ml[set] = (hw == 0);
    rd = word;
  endtask

  task automatic doReq(string req, bit wr, int addr, logic [31:0] wd, logic [3:0] st,
                       output bit gotHit);
    bit          expHit;
    logic [31:0] expRd;
    int          exQ[$];
    int          acc, n;
    modelAccess(wr, addr, wd, st, expHit, expRd, exQ);
    evQ.delete();
    @(negedge clk);
    check(req, "reqReady when idle", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = ADDR_W'(addr);
    reqWdata = wd; reqStrb = st; acc = cyc;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!rspValid && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(req, "response seen", {31'd0, rspValid}, 32'd1);
    if (expHit) check(req, "hit latency", cyc, acc + 1);
    else        check(req, "miss latency after last refill read", cyc, lastHs + 2);
    check(req, "response data", rspRdata, expRd);
    check(req, "memory transfer count", evQ.size(), exQ.size());
    for (int i = 0; i < exQ.size() && i < evQ.size(); i++)
      check(req, "memory transfer kind/address", evQ[i], exQ[i]);
    foreach (evQ[i]) if (evQ[i] >= 1000) wbCount++;
    gotHit = (evQ.size() == 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit h;
    int seq[10]   = '{0, 2, 0, 1, 4, 0, 2, 3, 5, 4};
    bit expH[10]  = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0};
    for (int i = 0; i < MEM_N; i++) begin
      bmem[i]   = 32'h5A00_0000 + i * 32'h0001_0101;
      refMem[i] = 32'h5A00_0000 + i * 32'h0001_0101;
    end
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqAddr = '0; reqWdata = '0; reqStrb = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "reqReady after reset", {31'd0, reqReady}, 32'd1);
    check("R1", "rspValid after reset", {31'd0, rspValid}, 32'd0);
    check("R1", "memValid after reset", {31'd0, memValid}, 32'd0);

    // fixed sequence: 3rd access shows empty-way use (R5), 5th shows recency victim (R6)
    for (int i = 0; i < 10; i++) begin
      string tagName = (i == 2) ? "R5" : ((i == 4) ? "R6" : "R11");
      doReq(tagName, 1'b0, seq[i], 32'd0, 4'd0, h);
      check("R11", "hit pattern", {31'd0, h}, {31'd0, expH[i]});
    end

    // partial store hit then eviction of the modified block
    doReq("R7", 1'b1, 4, 32'hCAFE_BEEF, 4'b0011, h);
    check("R7", "store hit without memory transfer", {31'd0, h}, 32'd1);
    doReq("R7", 1'b0, 4, 32'd0, 4'd0, h);
    doReq("R8", 1'b0, 6, 32'd0, 4'd0, h);
    check("R8", "clean victim not written back", wbCount, 0);
    doReq("R8", 1'b0, 8, 32'd0, 4'd0, h);
    check("R8", "modified victim written back", wbCount, 1);
    doReq("R8", 1'b0, 4, 32'd0, 4'd0, h);
    doReq("R2", 1'b0, MEM_N - 1, 32'd0, 4'd0, h);
    doReq("R2", 1'b1, MEM_N - 2, 32'h1234_5678, 4'b1111, h);

    for (int i = 0; i < 300; i++) begin
      int a = $urandom % MEM_N;
      bit w = $urandom % 2;
      doReq((i % 2) ? "R9" : "R3", w, a, $urandom, 4'($urandom), h);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule